// File: doc/BRIEF.md
# Way-Parallel Load Pre-Decoder

This block sits in the fetch stage next to an N-way set-associative instruction cache. Each way's raw instruction word comes out of the data array in the same cycle as the tag comparison. One pre-decoder copy per way inspects its word while the tags are being compared. When the one-hot tag-hit vector arrives, it picks the result of the hitting way. No decoding waits on the hit, so identifying a load adds only a single mux level after the tag compare.

The pre-decoder looks for early-load candidates. A candidate is a load that always executes and forms its address as a base register plus an immediate. For each candidate it extracts the base register, the immediate offset and a 4-bit addressing-mode code, and raises a push request towards the early load queue. Every valid hit also passes its instruction word and fetch PC to the instruction queue, whether or not it is a candidate. All outputs are registered once at the end of the fetch stage.

Top module: `lpd_fetch_predecode`

## Requirements
- R1: While reset is high and in the first cycle after it, `elq_push_o`, `iq_valid_o` and every data output read zero.
- R2: A word is a candidate when all of the following hold: bits [31:28] equal 4'b1110, bits [27:26] equal 2'b01, bit 25 is 0 and bit 20 is 1. A valid hit on such a word sets `elq_push_o` one clock later.
- R3: A word with bit 25 set (register-offset form) never raises `elq_push_o`, whatever its other bits are.
- R4: A word whose bits [31:28] are anything other than 4'b1110 never raises `elq_push_o`.
- R5: A non-candidate word fetched on a valid hit sets `iq_valid_o` with `elq_push_o` low. This covers stores (bit 20 = 0) and words with bits [27:26] other than 2'b01.
- R6: On a push, `elq_base_o` = word[19:16], `elq_offset_o` = word[11:0] and `elq_mode_o` = {word[24], word[23], word[22], word[21]}, all taken from the word of the hitting way.
- R7: Only the way flagged in `tag_hit_i` affects the outputs. The words of the other ways are ignored. `tag_hit_i` is at most one-hot while `fetch_valid_i` is high.
- R8: A miss (`tag_hit_i` all zero) or a low `fetch_valid_i` gives `elq_push_o` = 0 and `iq_valid_o` = 0 one clock later.
- R9: One clock after a valid hit, `iq_insn_o` holds the hitting way's word and `iq_pc_o` holds `fetch_pc_i`.
- R10: Whenever `elq_push_o` is low, `elq_base_o`, `elq_offset_o` and `elq_mode_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch slot holds a real request |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| way_words_i | input | WAYS*32 | Raw instruction word per way, way w at [w*32 +: 32] |
| tag_hit_i | input | WAYS | One-hot tag-compare hit vector |
| iq_valid_o | output | 1 | Instruction queue push |
| iq_insn_o | output | 32 | Selected instruction word |
| iq_pc_o | output | PC_W | PC for the instruction queue |
| elq_push_o | output | 1 | Early load queue push (candidate found) |
| elq_base_o | output | 4 | Base register index |
| elq_offset_o | output | 12 | Immediate offset |
| elq_mode_o | output | 4 | Addressing-mode code |

## Verification
Suppose a way's decoder, or the selection, picks up a wrong internal value. The fault shows up one clock later as a wrong push flag or wrong fields, attributed to the hitting way. A misrouted selection appears when the hitting way holds a non-candidate and a neighbouring way holds a candidate, or the reverse. A faulty gate on misses shows as a push or queue write in the cycle after a miss. The stimulus therefore puts different words in every way. It moves the hit across all ways and varies each qualifying bit one at a time.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int INSN_W     = 32;
  localparam int BASE_W     = 4;
  localparam int OFS_W      = 12;
  localparam int MODE_W     = 4;
  localparam int COND_HI    = 31;
  localparam int COND_LO    = 28;
  localparam int CLASS_HI   = 27;
  localparam int CLASS_LO   = 26;
  localparam int REGOFS_BIT = 25;
  localparam int MODE_HI    = 24;
  localparam int MODE_LO    = 21;
  localparam int LOAD_BIT   = 20;
  localparam int BASE_HI    = 19;
  localparam int BASE_LO    = 16;
  localparam int OFS_HI     = 11;
  localparam logic [3:0] COND_ALWAYS = 4'b1110;
  localparam logic [1:0] CLASS_XFER  = 2'b01;

  typedef struct packed {
    logic [INSN_W-1:0] word;
    logic              cand;
    logic [BASE_W-1:0] base;
    logic [OFS_W-1:0]  ofs;
    logic [MODE_W-1:0] mode;
  } pd_res_t;

  localparam int RES_W = $bits(pd_res_t);
endpackage

// File: rtl/lpd_way_decoder.sv
module lpd_way_decoder
  import lpd_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output pd_res_t           res_o
);
  logic cond_ok, class_ok, imm_form, is_load;

  always_comb begin
    cond_ok  = (word_i[COND_HI:COND_LO] == COND_ALWAYS);
    class_ok = (word_i[CLASS_HI:CLASS_LO] == CLASS_XFER);
    imm_form = ~word_i[REGOFS_BIT];
    is_load  = word_i[LOAD_BIT];
    res_o.word = word_i;
    res_o.cand = cond_ok & class_ok & imm_form & is_load;
    res_o.base = word_i[BASE_HI:BASE_LO];
    res_o.ofs  = word_i[OFS_HI:0];
    res_o.mode = word_i[MODE_HI:MODE_LO];
  end
endmodule

// File: rtl/lpd_onehot_mux.sv
module lpd_onehot_mux #(
  parameter int WIDTH = 8,
  parameter int NUM   = 4
) (
  input  logic [NUM*WIDTH-1:0] in_i,
  input  logic [NUM-1:0]       sel_i,
  output logic [WIDTH-1:0]     out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < NUM; i++) begin
      out_o = out_o | (in_i[i*WIDTH +: WIDTH] & {WIDTH{sel_i[i]}});
    end
  end
endmodule

// File: rtl/lpd_fetch_predecode.sv
module lpd_fetch_predecode
  import lpd_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int PC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fetch_valid_i,
  input  logic [PC_W-1:0]        fetch_pc_i,
  input  logic [WAYS*INSN_W-1:0] way_words_i,
  input  logic [WAYS-1:0]        tag_hit_i,
  output logic                   iq_valid_o,
  output logic [INSN_W-1:0]      iq_insn_o,
  output logic [PC_W-1:0]        iq_pc_o,
  output logic                   elq_push_o,
  output logic [BASE_W-1:0]      elq_base_o,
  output logic [OFS_W-1:0]       elq_offset_o,
  output logic [MODE_W-1:0]      elq_mode_o
);
  localparam int FLAT_W = WAYS * RES_W;

  logic [FLAT_W-1:0] way_res_flat;
  logic [RES_W-1:0]  sel_bits;
  pd_res_t           sel_res;
  logic              hit_ok, push_d;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    pd_res_t r;
    lpd_way_decoder u_dec (
      .word_i (way_words_i[w*INSN_W +: INSN_W]),
      .res_o  (r)
    );
    assign way_res_flat[w*RES_W +: RES_W] = r;
  end

  lpd_onehot_mux #(.WIDTH(RES_W), .NUM(WAYS)) u_sel (
    .in_i  (way_res_flat),
    .sel_i (tag_hit_i),
    .out_o (sel_bits)
  );

  assign sel_res = pd_res_t'(sel_bits);
  assign hit_ok  = fetch_valid_i & (|tag_hit_i);
  assign push_d  = hit_ok & sel_res.cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      iq_valid_o   <= 1'b0;
      iq_insn_o    <= '0;
      iq_pc_o      <= '0;
      elq_push_o   <= 1'b0;
      elq_base_o   <= '0;
      elq_offset_o <= '0;
      elq_mode_o   <= '0;
    end else begin
      iq_valid_o   <= hit_ok;
      iq_insn_o    <= hit_ok ? sel_res.word : '0;
      iq_pc_o      <= hit_ok ? fetch_pc_i : '0;
      elq_push_o   <= push_d;
      elq_base_o   <= push_d ? sel_res.base : '0;
      elq_offset_o <= push_d ? sel_res.ofs  : '0;
      elq_mode_o   <= push_d ? sel_res.mode : '0;
    end
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_i |-> $onehot0(tag_hit_i)); // R7

  AST_NO_PUSH_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid_i || tag_hit_i == '0) |=> (!elq_push_o && !iq_valid_o)); // R8

  AST_PUSH_NEEDS_IQ: assert property (@(posedge clk) disable iff (rst)
    elq_push_o |-> iq_valid_o); // R5

  AST_PUSH_FORM_OK: assert property (@(posedge clk) disable iff (rst)
    elq_push_o |-> (iq_insn_o[COND_HI:COND_LO] == COND_ALWAYS && !iq_insn_o[REGOFS_BIT])); // R3

  AST_FIELDS_MATCH_WORD: assert property (@(posedge clk) disable iff (rst)
    elq_push_o |-> (elq_base_o == iq_insn_o[BASE_HI:BASE_LO] &&
                    elq_offset_o == iq_insn_o[OFS_HI:0])); // R6

  AST_FIELDS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !elq_push_o |-> (elq_base_o == '0 && elq_offset_o == '0 && elq_mode_o == '0)); // R10

  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i && tag_hit_i != '0) |=> (iq_pc_o == $past(fetch_pc_i))); // R9
endmodule

// File: tb/lpd_fetch_predecode_tb_top.sv
`timescale 1ns/1ps
module lpd_fetch_predecode_tb_top;
  localparam int WAYS = 4;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid_i = 1'b0;
  logic [PC_W-1:0] fetch_pc_i = '0;
  logic [WAYS*32-1:0] way_words_i = '0;
  logic [WAYS-1:0] tag_hit_i = '0;
  logic iq_valid_o, elq_push_o;
  logic [31:0] iq_insn_o;
  logic [PC_W-1:0] iq_pc_o;
  logic [3:0] elq_base_o, elq_mode_o;
  logic [11:0] elq_offset_o;

  always #2.5 clk = ~clk;

  lpd_fetch_predecode #(.WAYS(WAYS), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .way_words_i(way_words_i), .tag_hit_i(tag_hit_i), .iq_valid_o(iq_valid_o),
    .iq_insn_o(iq_insn_o), .iq_pc_o(iq_pc_o), .elq_push_o(elq_push_o),
    .elq_base_o(elq_base_o), .elq_offset_o(elq_offset_o), .elq_mode_o(elq_mode_o));

  typedef struct {
    string       tag;
    logic        iqv;
    logic [31:0] insn;
    logic [31:0] pc;
    logic        push;
    logic [3:0]  base;
    logic [11:0] ofs;
    logic [3:0]  mode;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] mk(logic [3:0] cond, logic [1:0] cls, logic rb,
      logic [3:0] m, logic ld, logic [3:0] rn, logic [3:0] rd, logic [11:0] imm);
    return {cond, cls, rb, m, ld, rn, rd, imm};
  endfunction

  task automatic drive(string tag, logic v, logic [31:0] pc,
                       logic [WAYS*32-1:0] words, logic [WAYS-1:0] hit);
    exp_t e;
    logic [31:0] w;
    logic hv;
    @(negedge clk);
    fetch_valid_i = v; fetch_pc_i = pc; way_words_i = words; tag_hit_i = hit;
    w = '0;
    for (int i = 0; i < WAYS; i++) if (hit[i]) w = words[i*32 +: 32];
    hv = v && (hit != '0);
    e.tag  = tag;
    e.iqv  = hv;
    e.insn = hv ? w : '0;
    e.pc   = hv ? pc : '0;
    e.push = hv && w[31:28] == 4'b1110 && w[27:26] == 2'b01 && !w[25] && w[20];
    e.base = e.push ? w[19:16] : '0;
    e.ofs  = e.push ? w[11:0] : '0;
    e.mode = e.push ? {w[24], w[23], w[22], w[21]} : '0;
    sb.push_back(e);
  endtask

  task automatic idle_in();
    @(negedge clk);
    fetch_valid_i = 1'b0; tag_hit_i = '0;
  endtask

  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (!rst && sb.size() > 0) begin
      e = sb.pop_front();
      n_chk++;
      if (iq_valid_o !== e.iqv || iq_insn_o !== e.insn || iq_pc_o !== e.pc ||
          elq_push_o !== e.push || elq_base_o !== e.base || elq_offset_o !== e.ofs ||
          elq_mode_o !== e.mode) begin
        n_bad++;
        $display("FAIL %s: got v=%0b insn=%h pc=%h push=%0b b=%h o=%h m=%h exp v=%0b insn=%h pc=%h push=%0b b=%h o=%h m=%h",
          e.tag, iq_valid_o, iq_insn_o, iq_pc_o, elq_push_o, elq_base_o, elq_offset_o, elq_mode_o,
          e.iqv, e.insn, e.pc, e.push, e.base, e.ofs, e.mode);
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [WAYS*32-1:0] ww;
    logic [31:0] cand, rr, st, dp, nv;
    repeat (3) @(posedge clk);
    #1;
    n_chk++; // R1: reset values
    if (iq_valid_o !== 1'b0 || elq_push_o !== 1'b0 || iq_insn_o !== '0 || iq_pc_o !== '0 ||
        elq_base_o !== '0 || elq_offset_o !== '0 || elq_mode_o !== '0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b push=%0b insn=%h exp all zero", iq_valid_o, elq_push_o, iq_insn_o);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    n_chk++; // R1: first cycle after reset
    if (iq_valid_o !== 1'b0 || elq_push_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b push=%0b exp 0 0", iq_valid_o, elq_push_o);
    end

    cand = mk(4'b1110, 2'b01, 1'b0, 4'b1100, 1'b1, 4'h3, 4'h2, 12'h0A4);
    rr   = mk(4'b1110, 2'b01, 1'b1, 4'b1100, 1'b1, 4'h3, 4'h2, 12'h004);
    st   = mk(4'b1110, 2'b01, 1'b0, 4'b1100, 1'b0, 4'h3, 4'h2, 12'h010);
    dp   = mk(4'b1110, 2'b00, 1'b0, 4'b1100, 1'b1, 4'h3, 4'h2, 12'h010);
    nv   = mk(4'b0000, 2'b01, 1'b0, 4'b1100, 1'b1, 4'h3, 4'h2, 12'h010);

    drive("R2", 1, 32'h100, {3{32'h0}} << 0 | {96'h0, cand}, 4'b0001);
    for (int w = 0; w < WAYS; w++) begin
      ww = '0;
      ww[w*32 +: 32] = mk(4'b1110, 2'b01, 1'b0, 4'(w*5+1), 1'b1, 4'(w+9), 4'h1, 12'hF00 | 12'(w));
      drive("R6", 1, 32'h200 + 32'(w*4), ww, 4'(1 << w));
    end
    drive("R3", 1, 32'h300, {96'h0, rr}, 4'b0001);
    drive("R4", 1, 32'h304, {rr, st, dp, nv}, 4'b0001);
    drive("R5", 1, 32'h308, {96'h0, st} << 32, 4'b0010);
    drive("R5", 1, 32'h30C, {dp, 96'h0}, 4'b1000);
    drive("R7", 1, 32'h400, {cand, cand, st, cand}, 4'b0010);
    drive("R7", 1, 32'h404, {rr, cand, nv, dp}, 4'b0100);
    drive("R8", 1, 32'h500, {cand, cand, cand, cand}, 4'b0000);
    drive("R8", 0, 32'h504, {cand, cand, cand, cand}, 4'b0001);
    drive("R10", 1, 32'h508, {cand, cand, cand, cand}, 4'b0001);
    drive("R10", 1, 32'h50C, {cand, cand, cand, nv}, 4'b0001);
    drive("R9", 1, 32'hDEAD_BEE0, {cand, rr, st, dp}, 4'b0100);
    for (int c = 0; c < 16; c++) begin
      logic [31:0] wv;
      wv = mk(4'b1110, 2'b01, 1'b0, 4'(c), 1'b1, 4'(15 - c), 4'h0, 12'(c * 257));
      drive("R6", 1, 32'h600 + 32'(c), {4{wv}}, 4'(1 << (c % 4)));
    end
    for (int c = 0; c < 300; c++) begin
      logic [WAYS*32-1:0] rw;
      logic [WAYS-1:0] hh;
      for (int w = 0; w < WAYS; w++) begin
        rw[w*32 +: 32] = $urandom;
        if ($urandom % 2 == 0) rw[w*32+26 +: 6] = 6'b111001;
        if ($urandom % 3 != 0) rw[w*32+20] = 1'b1;
      end
      hh = ($urandom % 5 == 0) ? 4'b0000 : 4'(1 << ($urandom % 4));
      drive("R2", ($urandom % 8) != 0, $urandom, rw, hh);
    end
    idle_in();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule